// File: doc/BRIEF.md
# GPIO Port Edge-Interrupt Controller

This block watches an eight-pin general-purpose port and turns chosen signal edges on each pin into interrupt events. Every pin has three control bits held in byte-wide registers: an interrupt enable, an edge polarity select and a sticky event flag. Each pin input passes through a two-flop synchronizer. A rising or falling transition, whichever the polarity bit selects, sets the pin's flag. The flag holds until software writes a 1 to its bit. One registered request line goes to the system interrupt controller. It stays high while any flagged pin is also enabled.

The block also works out the effective pull-up enable for each pad. When a pin runs as plain I/O, the pull-up applies only while the output driver is off. When a pin is given to an alternate function, the pull-up follows a default supplied by that function, and the software pull-up bit no longer matters.

Top module: `gpio_edge_irq`

## Requirements
- R1: Registers decode on a 16-bit byte address: enable at 0x5205, edge select at 0x5206, flags at 0x5207, with bit i of each belonging to pin i. A read strobe returns the addressed register on `bus_rdata` one clock later. Any other address, or a cycle with no read strobe, returns 0.
- R2: After reset, the enable, edge-select and flag registers are all 0, and `irq_req` and `bus_rdata` are low.
- R3: A pin whose edge-select bit is 0 sets its flag on a 0-to-1 input transition only. A pin whose edge-select bit is 1 sets its flag on a 1-to-0 transition only. No flag is set without such a transition.
- R4: An input change captured at clock edge k sets the flag at edge k+2 and can raise `irq_req` at edge k+3, but not earlier.
- R5: Writing the flag register clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. Flags are otherwise sticky.
- R6: If an edge event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R7: `irq_req` is high one cycle after any pin has both its flag and its enable at 1, and low one cycle after no pin does. A disabled pin's flag has no effect on the request.
- R8: For a pin with alternate function off, `pu_eff` is high exactly when its pull-up bit is 1 and its output enable is 0.
- R9: For a pin with alternate function on, `pu_eff` equals that pin's function default, whatever its pull-up bit and output enable are.
- R10: Reading any register has no side effect. In particular, reading the flags leaves them unchanged.
- R11: Writing a 1 to the flag register never sets a flag. Writes to the enable and edge-select registers replace their whole contents.
- R12: Flags record events on disabled pins. Enabling a pin whose flag is already set raises `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Asynchronous pad input levels |
| bus_addr | input | 16 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pu_bit | input | 8 | Software pull-up request per pin |
| oe | input | 8 | Output driver enable per pin |
| alt_sel | input | 8 | Pin assigned to an alternate function |
| alt_pu_dflt | input | 8 | Pull-up wanted by the alternate function |
| pu_eff | output | 8 | Effective pull-up enable per pin |
| irq_req | output | 1 | Combined interrupt request |

## Verification
Two things can reach the same flag bit in one clock: the synchronized detection of a selected edge and a software write-1 clear. The bench provokes this by timing a pin transition so that the synchronizer delivers it on the exact edge where a flag write is sampled. The write mask covers both the colliding bit and an already-set neighbour. The result is judged by reading the flags back: the colliding bit must remain set, the neighbour must be cleared, and the request must remain high while the colliding pin is enabled.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int NPINS = 8;
    localparam int AW    = 16;

    localparam logic [AW-1:0] ADDR_IEN  = 16'h5205;
    localparam logic [AW-1:0] ADDR_EDGE = 16'h5206;
    localparam logic [AW-1:0] ADDR_FLAG = 16'h5207;

    typedef logic [NPINS-1:0] pinvec_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_IEN  = 2'd1,
        SEL_EDGE = 2'd2,
        SEL_FLAG = 2'd3
    } regsel_e;

    typedef struct packed {
        logic    wr;
        logic    rd;
        regsel_e sel;
        pinvec_t wdata;
    } busreq_t;

    function automatic regsel_e decode_addr(input logic [AW-1:0] a);
        regsel_e s;
        case (a)
            ADDR_IEN:  s = SEL_IEN;
            ADDR_EDGE: s = SEL_EDGE;
            ADDR_FLAG: s = SEL_FLAG;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Per-pin event: polarity 1 picks the falling transition.
    function automatic pinvec_t pick_edge(input pinvec_t rise,
                                          input pinvec_t fall,
                                          input pinvec_t pol);
        return (pol & fall) | (~pol & rise);
    endfunction

endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge
    import gpio_irq_pkg::*;
#(
    parameter int N      = NPINS,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_async,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    localparam int CHAIN = STAGES + 1;

    for (genvar p = 0; p < N; p++) begin : g_pin
        logic [CHAIN-1:0] chain;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
            end else begin
                chain <= {chain[CHAIN-2:0], pin_async[p]};
            end
        end

        // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous sample
        assign rise[p] =  chain[STAGES-1] & ~chain[STAGES];
        assign fall[p] = ~chain[STAGES-1] &  chain[STAGES];
    end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  busreq_t req,
    input  pinvec_t set_ev,
    output pinvec_t ien,
    output pinvec_t esel,
    output pinvec_t flags,
    output pinvec_t rdata
);
    pinvec_t clr_mask;
    pinvec_t flags_n;
    pinvec_t rd_mux;

    assign clr_mask = (req.wr && req.sel == SEL_FLAG) ? req.wdata : '0;

    // Set is applied after clear, so a same-cycle event survives.
    for (genvar b = 0; b < NPINS; b++) begin : g_flag
        assign flags_n[b] = set_ev[b] | (flags[b] & ~clr_mask[b]);
    end

    always_comb begin
        case (req.sel)
            SEL_IEN:  rd_mux = ien;
            SEL_EDGE: rd_mux = esel;
            SEL_FLAG: rd_mux = flags;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien   <= '0;
            esel  <= '0;
            flags <= '0;
            rdata <= '0;
        end else begin
            if (req.wr && req.sel == SEL_IEN)  ien  <= req.wdata;
            if (req.wr && req.sel == SEL_EDGE) esel <= req.wdata;
            flags <= flags_n;
            rdata <= req.rd ? rd_mux : '0;
        end
    end

    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_FLAG) |=> ((flags & $past(req.wdata) & ~$past(set_ev)) == '0));

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.sel == SEL_FLAG) |=> (($past(flags) & ~flags) == '0));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (|set_ev) |=> ((flags & $past(set_ev)) == $past(set_ev)));

    assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (rst)
        !(|set_ev) |=> ((flags & ~$past(flags)) == '0));

endmodule

// File: rtl/gpio_pullup_gate.sv
module gpio_pullup_gate
    import gpio_irq_pkg::*;
#(
    parameter int N = NPINS
) (
    input  logic [N-1:0] pu_bit,
    input  logic [N-1:0] oe,
    input  logic [N-1:0] alt_sel,
    input  logic [N-1:0] alt_dflt,
    output logic [N-1:0] pu_eff
);
    for (genvar p = 0; p < N; p++) begin : g_pu
        assign pu_eff[p] = alt_sel[p] ? alt_dflt[p] : (pu_bit[p] & ~oe[p]);
    end

    always_comb begin
        assert_pu_oe_R8: assert ((pu_eff & oe & ~alt_sel) == '0);
    end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  pin_in,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  pu_bit,
    input  logic [7:0]  oe,
    input  logic [7:0]  alt_sel,
    input  logic [7:0]  alt_pu_dflt,
    output logic [7:0]  pu_eff,
    output logic        irq_req
);
    busreq_t req;
    pinvec_t rise, fall, set_ev;
    pinvec_t ien, esel, flags;

    assign req.wr    = bus_wr;
    assign req.rd    = bus_rd;
    assign req.sel   = decode_addr(bus_addr);
    assign req.wdata = bus_wdata;

    gpio_sync_edge #(.N(NPINS), .STAGES(2)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (pin_in),
        .rise      (rise),
        .fall      (fall)
    );

    assign set_ev = pick_edge(rise, fall, esel);

    gpio_irq_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .set_ev (set_ev),
        .ien    (ien),
        .esel   (esel),
        .flags  (flags),
        .rdata  (bus_rdata)
    );

    gpio_pullup_gate #(.N(NPINS)) u_pu (
        .pu_bit   (pu_bit),
        .oe       (oe),
        .alt_sel  (alt_sel),
        .alt_dflt (alt_pu_dflt),
        .pu_eff   (pu_eff)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_req <= 1'b0;
        else     irq_req <= |(flags & ien);
    end

    assert_irq_on_R7: assert property (@(posedge clk) disable iff (rst)
        (|(flags & ien)) |=> irq_req);

    assert_irq_off_R7: assert property (@(posedge clk) disable iff (rst)
        ((flags & ien) == '0) |=> !irq_req);

endmodule

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pin_in = '0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pu_bit = '0, oe = '0, alt_sel = '0, alt_pu_dflt = '0;
    logic [7:0]  pu_eff;
    logic        irq_req;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    localparam logic [15:0] A_IEN = 16'h5205, A_EDGE = 16'h5206, A_FLAG = 16'h5207;

    logic [7:0] m_en = '0, m_edge = '0, m_flag = '0, m_pin = '0;

    always #10 clk = ~clk;

    gpio_edge_irq u_dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pu_bit(pu_bit), .oe(oe), .alt_sel(alt_sel), .alt_pu_dflt(alt_pu_dflt),
        .pu_eff(pu_eff), .irq_req(irq_req)
    );

    function automatic logic [7:0] exp_events(logic [7:0] oldv, logic [7:0] newv, logic [7:0] pol);
        return (pol & oldv & ~newv) | (~pol & ~oldv & newv);
    endfunction

    function automatic logic [7:0] exp_pu(logic [7:0] pu, logic [7:0] o, logic [7:0] alt, logic [7:0] d);
        return (alt & d) | (~alt & pu & ~o);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_pins(logic [7:0] v);
        pin_in = v;
        repeat (4) @(negedge clk);
        m_flag = m_flag | exp_events(m_pin, v, m_edge);
        m_pin = v;
    endtask

    task automatic check_flags(string req);
        logic [7:0] d;
        rd(A_FLAG, d);
        check(req, d, m_flag);
        check(req, irq_req, |(m_flag & m_en));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        check("R2 irq", irq_req, 0);
        check("R2 rdata", bus_rdata, 0);
        rd(A_IEN, d);  check("R2 ien", d, 0);
        rd(A_EDGE, d); check("R2 edge", d, 0);
        rd(A_FLAG, d); check("R2 flag", d, 0);

        // R1 / R11 map and write behaviour
        wr(A_IEN, 8'hA5);  rd(A_IEN, d);  check("R1 ien readback", d, 8'hA5);
        wr(A_EDGE, 8'h3C); rd(A_EDGE, d); check("R1 edge readback", d, 8'h3C);
        rd(16'h5204, d); check("R1 unmapped read", d, 0);
        rd(16'h5208, d); check("R1 unmapped read", d, 0);
        @(negedge clk);  check("R1 no strobe rdata", bus_rdata, 0);
        wr(A_FLAG, 8'hFF); rd(A_FLAG, d); check("R11 write1 no set", d, 0);
        wr(A_IEN, 8'h00); wr(A_EDGE, 8'h02);
        m_en = 8'h00; m_edge = 8'h02;

        // R3 polarity
        set_pins(8'h03); check_flags("R3 rise on pin0 only");
        set_pins(8'h00); check_flags("R3 fall on pin1 only");
        wr(A_FLAG, 8'hFF); m_flag = 0; check_flags("R5 clear all");

        // R12 disabled pin flag then enable
        set_pins(8'h10); check("R12 disabled irq", irq_req, 0);
        wr(A_IEN, 8'h10); m_en = 8'h10; @(negedge clk);
        check("R12 enable pending", irq_req, 1);
        // R10 read has no side effect
        rd(A_FLAG, d); rd(A_FLAG, d); check("R10 flags kept", d, 8'h10);
        // R5 partial clear
        set_pins(8'h30);
        wr(A_FLAG, 8'h20); m_flag = m_flag & ~8'h20; check_flags("R5 partial clear");
        wr(A_FLAG, 8'h10); m_flag = 0; @(negedge clk);
        check("R7 irq drops", irq_req, 0);

        // R4 latency: enable pin2, change drives at negedge before edge k
        wr(A_IEN, 8'h14); m_en = 8'h14;
        pin_in = 8'h34;
        @(negedge clk); check("R4 no irq after k", irq_req, 0);
        @(negedge clk); check("R4 no irq after k+1", irq_req, 0);
        @(negedge clk); check("R4 no irq after k+2", irq_req, 0);
        @(negedge clk); check("R4 irq after k+3", irq_req, 1);
        m_flag = 8'h04; m_pin = 8'h34;
        check_flags("R4 flag");

        // R6 collision: pin3 rise delivered on the edge that samples a clear of bits 3 and 2
        pin_in = 8'h3C;
        @(negedge clk);
        @(negedge clk);
        wr(A_FLAG, 8'h0C);
        m_flag = 8'h08; m_pin = 8'h3C;
        wr(A_IEN, 8'h08); m_en = 8'h08;
        @(negedge clk);
        check_flags("R6 set wins");
        wr(A_FLAG, 8'hFF); m_flag = 0; @(negedge clk);

        // R8 / R9 pull-up gating
        for (int i = 0; i < 40; i++) begin
            pu_bit = $urandom; oe = $urandom; alt_pu_dflt = $urandom;
            alt_sel = (i < 20) ? 8'h00 : $urandom;
            #1;
            check(i < 20 ? "R8 pull-up gate" : "R9 alt default", pu_eff,
                  exp_pu(pu_bit, oe, alt_sel, alt_pu_dflt));
        end
        alt_sel = 8'hFF; pu_bit = 8'h00; oe = 8'hFF; alt_pu_dflt = 8'h5A; #1;
        check("R9 alt ignores pu/oe", pu_eff, 8'h5A);

        // Random mix
        for (int i = 0; i < 80; i++) begin
            case ($urandom % 4)
                0: begin m_en = $urandom; wr(A_IEN, m_en); end
                1: begin m_edge = $urandom; wr(A_EDGE, m_edge); end
                2: begin logic [7:0] mk; mk = $urandom; wr(A_FLAG, mk); m_flag = m_flag & ~mk; end
                default: set_pins($urandom);
            endcase
            @(negedge clk);
            check_flags("R3 R7 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule